// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator

This block produces the sixteen-times oversampling strobe that paces a UART's transmitter and receiver. A 16-bit down-counter is loaded from a programmable divisor, counts down by one on each system clock, and on reaching one it reloads and emits a single-clock tick. The tick rate is the clock frequency divided by the divisor, so the serial bit rate is the clock divided by sixteen times the divisor.

Software reaches the divisor through a small byte-wide register port. There are two divisor bytes and one 8-bit line-control register. Only the top bit of line-control has a function here: while it is set, the divisor bytes can be read and written. While it is clear, they are hidden and protected. The other line-control bits are stored and read back only. Writing either divisor byte restarts the count at once from the new 16-bit value.

Top module: `uart_rate_gen`

## Requirements
- R1: After reset the divisor is 0x0002, line-control reads 0x00 and `tick_o` is low. The first tick appears on the second clock edge after reset is released, and ticks then repeat every 2 clocks.
- R2: For a divisor D of 2 or more, `tick_o` is high for exactly one clock in every D clocks.
- R3: A divisor of 0x0001 drives `tick_o` high on every clock.
- R4: A divisor of 0x0000 behaves exactly like 0x0001. The counter value is never zero.
- R5: A write to either divisor byte loads the counter with the full value {high byte, low byte}, built with the newly written byte. `tick_o` is low after that write edge even if a tick was due. The next tick comes D clocks after the write edge.
- R6: While line-control bit 7 is 1, address 0 reads and writes the low divisor byte and address 1 reads and writes the high divisor byte. While bit 7 is 0, reads of addresses 0 and 1 return 0x00.
- R7: While line-control bit 7 is 0, writes to addresses 0 and 1 change neither the stored divisor nor the count phase.
- R8: Address 2 holds the 8-bit line-control value. It can be written and read back at any time, and writing it does not disturb the count.
- R9: `rdata_o` is combinational from `addr_i`. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address: 0 divisor low, 1 divisor high, 2 line-control |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| tick_o | output | 1 | One-clock strobe at sixteen times the bit rate |

## Verification
The embedded properties hold on every cycle. They check that the counter steps down by exactly one between reloads and never holds zero. They check that every tick coincides with a reload to the effective divisor, that no tick follows a divisor write edge, and that locked writes leave the stored divisor unchanged and read as zero. Some behaviours can only be shown by the bench's scenarios, which measure tick spacing at the port. These are the whole-period spacing for a given divisor, the merge of a single written byte with the old one, the placement of the first tick after a restart, and the continued count phase across locked writes and line-control writes.

// File: rtl/urg_pkg.sv
package urg_pkg;
   // Which register an access selects
   typedef enum logic [1:0] {
      URG_SEL_NONE = 2'd0,
      URG_SEL_DIV  = 2'd1,
      URG_SEL_CTRL = 2'd2
   } urg_sel_e;
endpackage

// File: rtl/urg_regs.sv
module urg_regs #(
   parameter int BYTE_W    = 8,
   parameter int NBYTES    = 2,
   parameter int ADDR_W    = 2,
   parameter int RESET_DIV = 2,
   parameter int GATE_BIT  = 7,
   localparam int CNT_W    = BYTE_W * NBYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [CNT_W-1:0]  div_next_o,
   output logic              load_o,
   output logic [BYTE_W-1:0] rdata_o
);
   import urg_pkg::*;

   localparam logic [CNT_W-1:0]  RST_VAL = CNT_W'(RESET_DIV);
   localparam logic [ADDR_W-1:0] CTRL_AD = ADDR_W'(NBYTES);

   logic [CNT_W-1:0]  div_q;
   logic [BYTE_W-1:0] ctrl_q;
   logic              gate;
   logic [NBYTES-1:0] wr_hit;
   logic [BYTE_W-1:0] rd_byte [NBYTES];
   urg_sel_e          sel;

   assign gate = ctrl_q[GATE_BIT];

   always_comb begin
      if (addr_i < CTRL_AD)       sel = URG_SEL_DIV;
      else if (addr_i == CTRL_AD) sel = URG_SEL_CTRL;
      else                        sel = URG_SEL_NONE;
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      logic hit;
      assign hit       = (sel == URG_SEL_DIV) && (addr_i == ADDR_W'(b)) && gate;
      assign wr_hit[b] = we_i && hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         div_q[b*BYTE_W +: BYTE_W] <= RST_VAL[b*BYTE_W +: BYTE_W];
         else if (wr_hit[b]) div_q[b*BYTE_W +: BYTE_W] <= wdata_i;
      end

      assign div_next_o[b*BYTE_W +: BYTE_W] = wr_hit[b] ? wdata_i : div_q[b*BYTE_W +: BYTE_W];
      assign rd_byte[b] = hit ? div_q[b*BYTE_W +: BYTE_W] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ctrl_q <= '0;
      else if (we_i && sel == URG_SEL_CTRL)   ctrl_q <= wdata_i;
   end

   assign load_o = |wr_hit;

   always_comb begin
      rdata_o = (sel == URG_SEL_CTRL) ? ctrl_q : '0;
      for (int b = 0; b < NBYTES; b++) rdata_o = rdata_o | rd_byte[b];
   end

   // R7: locked divisor writes leave the stored divisor untouched
   a_r7_locked_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !gate && sel == URG_SEL_DIV) |=> $stable(div_q));
   // R6: divisor reads are zero while access is closed
   a_r6_locked_read : assert property (@(posedge clk) disable iff (!rst_n)
      (!gate && sel == URG_SEL_DIV) |-> (rdata_o == '0));
   // R8: line-control holds the last written value
   a_r8_ctrl_store : assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && sel == URG_SEL_CTRL) |=> (ctrl_q == $past(wdata_i)));
endmodule

// File: rtl/urg_counter.sv
module urg_counter #(
   parameter int CNT_W      = 16,
   parameter int RESET_DIV  = 2,
   parameter bit CLAMP_ZERO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] div_i,
   output logic             tick_o
);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RESET_DIV);

   logic [CNT_W-1:0] eff;
   logic [CNT_W-1:0] cnt_q;
   logic             tick_q;

   if (CLAMP_ZERO) begin : g_clamp
      assign eff = (div_i == '0) ? ONE : div_i;
   end else begin : g_raw
      assign eff = div_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= RST_VAL;
         tick_q <= 1'b0;
      end else if (load_i) begin
         cnt_q  <= eff;
         tick_q <= 1'b0;
      end else if (cnt_q <= ONE) begin
         cnt_q  <= eff;
         tick_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_q - ONE;
         tick_q <= 1'b0;
      end
   end

   assign tick_o = tick_q;

   // R2: between reloads the count drops by exactly one
   a_r2_step_down : assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE && !tick_q));
   // R2: each tick coincides with a reload to the effective divisor
   a_r2_tick_reload : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick_q) |-> (cnt_q == $past(eff)));
   // R4: the counter never holds zero
   a_r4_never_zero : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0);
   // R5: a divisor write edge produces no tick
   a_r5_load_no_tick : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !tick_q);
endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen #(
   parameter int BYTE_W    = 8,
   parameter int CNT_W     = 16,
   parameter int ADDR_W    = 2,
   parameter int RESET_DIV = 2,
   parameter int GATE_BIT  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   output logic              tick_o
);
   localparam int NBYTES = CNT_W / BYTE_W;

   if (CNT_W % BYTE_W != 0) begin : g_bad_width
      $error("CNT_W must be a whole number of bytes");
   end
   if (NBYTES + 1 > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (GATE_BIT >= BYTE_W || GATE_BIT < 0) begin : g_bad_gate
      $error("GATE_BIT outside the control byte");
   end
   if (RESET_DIV < 1) begin : g_bad_reset
      $error("RESET_DIV must be at least 1");
   end

   logic [CNT_W-1:0] div_next;
   logic             load;

   urg_regs #(
      .BYTE_W(BYTE_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W),
      .RESET_DIV(RESET_DIV), .GATE_BIT(GATE_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .we_i(we_i),
      .wdata_i(wdata_i), .div_next_o(div_next), .load_o(load),
      .rdata_o(rdata_o)
   );

   urg_counter #(
      .CNT_W(CNT_W), .RESET_DIV(RESET_DIV), .CLAMP_ZERO(1'b1)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .load_i(load), .div_i(div_next),
      .tick_o(tick_o)
   );
endmodule

// File: tb/sim_uart_rate_gen.sv
module sim_uart_rate_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       we = 1'b0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       tick;

   int checks = 0;
   int errors = 0;
   int since = 0;

   always #5 clk = ~clk;

   uart_rate_gen u0 (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .we_i(we),
      .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick)
   );

   function automatic int eff_of(input logic [15:0] d);
      return (d == 16'd0) ? 1 : int'(d);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input int exp, input string tag);
      addr = a;
      #1;
      chk(tag, int'(rdata), exp);
   endtask

   // step one edge and check the tick phase, d = effective divisor
   task automatic step(input int d, input string tag);
      @(negedge clk);
      since++;
      chk(tag, int'(tick), (since % d == 0) ? 1 : 0);
   endtask

   // a write that is not a divisor load: phase must continue
   task automatic wr_keep(input logic [1:0] a, input logic [7:0] d, input int e, input string tag);
      wr(a, d);
      since++;
      chk(tag, int'(tick), (since % e == 0) ? 1 : 0);
   endtask

   task automatic set_div(input logic [15:0] d, input bit hi_last, input string tag);
      if (hi_last) begin wr(2'd0, d[7:0]); wr(2'd1, d[15:8]); end
      else         begin wr(2'd1, d[15:8]); wr(2'd0, d[7:0]); end
      chk(tag, int'(tick), 0);
      since = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic [7:0]  ctl;
      int          e;
      void'($urandom(32'd20240601));
      repeat (3) @(negedge clk);
      chk("R1 tick in reset", int'(tick), 0);
      rst_n = 1'b1;
      since = 0;
      // R1: period 2 from reset
      for (int i = 0; i < 6; i++) step(2, "R1 reset period");
      rd(2'd2, 8'h00, "R1 ctrl reset");
      rd(2'd0, 8'h00, "R6 locked low read");
      rd(2'd3, 8'h00, "R9 unused addr");
      wr_keep(2'd2, 8'h80, 2, "R8 ctrl write keeps phase");
      rd(2'd0, 8'h02, "R1 divisor low reset");
      rd(2'd1, 8'h00, "R1 divisor high reset");
      rd(2'd2, 8'h80, "R8 ctrl readback");

      // R3: divisor 1
      set_div(16'h0001, 1'b1, "R5 no tick on write");
      for (int i = 0; i < 5; i++) step(1, "R3 every clock");
      // R4: divisor 0
      set_div(16'h0000, 1'b0, "R5 no tick on write");
      for (int i = 0; i < 5; i++) step(1, "R4 zero as one");
      rd(2'd0, 8'h00, "R4 raw zero low");
      // R5: single-byte write merges with the old byte
      set_div(16'h0005, 1'b1, "R5 no tick on write");
      for (int i = 0; i < 10; i++) step(5, "R2 period 5");
      wr(2'd0, 8'h03);
      chk("R5 low-only write", int'(tick), 0);
      since = 0;
      for (int i = 0; i < 6; i++) step(3, "R5 merged period 3");
      // R5: write on the edge a tick was due
      step(3, "R2 period 3");
      step(3, "R2 period 3");
      wr(2'd0, 8'h04);
      chk("R5 due tick suppressed", int'(tick), 0);
      since = 0;
      for (int i = 0; i < 8; i++) step(4, "R5 restart period 4");
      // large divisor
      set_div(16'h0102, 1'b1, "R5 no tick on write");
      for (int i = 0; i < 258; i++) step(258, "R2 period 258");
      rd(2'd1, 8'h01, "R6 high read");
      rd(2'd0, 8'h02, "R6 low read");

      // random mix
      for (int it = 0; it < 40; it++) begin
         d = 16'($urandom_range(0, 70));
         if (it % 9 == 4) d = 16'h0001;
         e = eff_of(d);
         set_div(d, 1'($urandom_range(0, 1)), "R5 no tick on write");
         for (int i = 0; i < 2 * e; i++) step(e, "R2 random period");
         rd(2'd0, int'(d[7:0]), "R6 random low read");
         rd(2'd1, int'(d[15:8]), "R6 random high read");
         // lock, try to change divisor, unlock
         ctl = 8'($urandom_range(0, 127));
         wr_keep(2'd2, ctl, e, "R8 lock write keeps phase");
         rd(2'd2, int'(ctl), "R8 ctrl random readback");
         rd(2'd0, 0, "R6 locked read zero");
         rd(2'd1, 0, "R6 locked read zero");
         wr_keep(2'd0, 8'($urandom), e, "R7 locked write no restart");
         wr_keep(2'd1, 8'($urandom), e, "R7 locked write no restart");
         wr_keep(2'd2, ctl | 8'h80, e, "R8 unlock keeps phase");
         rd(2'd0, int'(d[7:0]), "R7 divisor kept low");
         rd(2'd1, int'(d[15:8]), "R7 divisor kept high");
         rd(2'd3, 0, "R9 unused addr");
         for (int i = 0; i < e + 2; i++) step(e, "R7 phase continues");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule